// File: doc/BRIEF.md
# Preloadable Divide-by-N Clock Generator

This block divides a fast input clock by any integer N, not only by powers of two. It produces a one-cycle pulse every N input cycles, and also a square wave whose period is 2N input cycles with exactly 50% duty. The square wave comes from a single flip-flop that flips on every pulse.

Inside, a counter is loaded with a start value derived from the divisor. It advances one step per clock. When it reaches its terminal value, the terminal event does two things: it forms the output pulse, and it reloads the start value in the same cycle, so no extra cycle is lost. The counting direction is fixed at elaboration:
- Down mode loads N-1, counts down and ends on zero (the borrow).
- Up mode loads the complement of N-1, counts up and ends on all-ones (the carry).

Both modes give identical outputs.

The divisor input is read only when a reload happens. A change therefore never cuts short the period in progress.

Top module: `clkdiv_preload`

## Requirements
- R1: After the last clock edge with `rst` high (edge 0), `tick_o` is high in the cycle after edge N, edge 2N, edge 3N and so on, and low otherwise. Here N is the effective divisor, from 1 to 2^WIDTH.
- R2: For N of 2 or more, `tick_o` is high for exactly one clock cycle per period.
- R3: A down-counting instance (MODE = CNT_DOWN, encoded 0) and an up-counting instance (MODE = CNT_UP, encoded 1) with the same divisor produce identical `tick_o` and `sq_o` sequences.
- R4: A divisor value of 0 behaves as N = 1. A divisor above 2^WIDTH behaves as N = 2^WIDTH.
- R5: `sq_o` starts at 0 after reset and inverts in the cycle in which `tick_o` is high. Its period is 2N cycles: high for N cycles, then low for N cycles.
- R6: In the cycle after a clock edge with `rst` high, both `tick_o` and `sq_o` are 0. Counting then restarts from the beginning of a period.
- R7: A change of `div_i` inside a period takes effect only at the next reload. The period in progress completes with the old N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | WIDTH+1 | Divisor N, sampled at reset and at each reload |
| tick_o | output | 1 | Registered one-cycle pulse once per N cycles |
| sq_o | output | 1 | Registered 50% duty square wave of period 2N |

## Verification
The hardest situation to reach from the ports is a divisor change that lands strictly inside a period. The stimulus must hit a cycle that is neither a reload nor the reset. The bench arranges this as follows: it resets with N = 5, lets two cycles pass, and then moves the divisor to 3 on a falling edge. It then expects the next pulse at cycle 5 and the later ones every 3 cycles. The extreme divisors (0, 1, exactly 2^WIDTH and beyond it) are driven through the vector table. Every vector is run on a down-counting and an up-counting instance side by side.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_mode_e;

endpackage

// File: rtl/clkdiv_limit.sv
module clkdiv_limit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0] div_i,
  output logic [WIDTH:0] eff_o
);

  localparam logic [WIDTH:0] NMAX = {1'b1, {WIDTH{1'b0}}};
  localparam logic [WIDTH:0] NONE = {{WIDTH{1'b0}}, 1'b1};

  always_comb begin
    if (div_i == '0) begin
      eff_o = NONE;
    end else if (div_i > NMAX) begin
      eff_o = NMAX;
    end else begin
      eff_o = div_i;
    end
  end

endmodule

// File: rtl/clkdiv_preset.sv
module clkdiv_preset
  import clkdiv_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter cnt_mode_e MODE  = CNT_DOWN
) (
  input  logic [WIDTH:0]   eff_i,
  output logic [WIDTH-1:0] preset_o
);

  logic [WIDTH:0] span;

  // Number of steps between start value and terminal value.
  assign span = eff_i - {{WIDTH{1'b0}}, 1'b1};

  generate
    if (MODE == CNT_UP) begin : g_up
      // Start at MAX - (N-1) so the carry arrives after N cycles.
      assign preset_o = ~span[WIDTH-1:0];
    end else begin : g_down
      assign preset_o = span[WIDTH-1:0];
    end
  endgenerate

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter cnt_mode_e MODE  = CNT_DOWN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             term_o
);

  localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  generate
    if (MODE == CNT_UP) begin : g_up
      assign term_o = (cnt_q == {WIDTH{1'b1}});
      assign cnt_d  = term_o ? preset_i : (cnt_q + STEP);
    end else begin : g_down
      assign term_o = (cnt_q == '0);
      assign cnt_d  = term_o ? preset_i : (cnt_q - STEP);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= preset_i;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage (
  input  logic clk,
  input  logic rst,
  input  logic term_i,
  output logic tick_o,
  output logic sq_o
);

  logic tick_q;
  logic sq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      tick_q <= term_i;
      sq_q   <= sq_q ^ term_i;
    end
  end

  assign tick_o = tick_q;
  assign sq_o   = sq_q;

endmodule

// File: rtl/clkdiv_preload.sv
module clkdiv_preload
  import clkdiv_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter cnt_mode_e MODE  = CNT_DOWN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [WIDTH:0] div_i,
  output logic           tick_o,
  output logic           sq_o
);

  logic [WIDTH:0]   eff_w;
  logic [WIDTH-1:0] preset_w;
  logic [WIDTH-1:0] cnt_w;
  logic             term_w;

  clkdiv_limit #(.WIDTH(WIDTH)) u_limit (
    .div_i (div_i),
    .eff_o (eff_w)
  );

  clkdiv_preset #(.WIDTH(WIDTH), .MODE(MODE)) u_preset (
    .eff_i    (eff_w),
    .preset_o (preset_w)
  );

  clkdiv_counter #(.WIDTH(WIDTH), .MODE(MODE)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .preset_i (preset_w),
    .cnt_o    (cnt_w),
    .term_o   (term_w)
  );

  clkdiv_outstage u_out (
    .clk    (clk),
    .rst    (rst),
    .term_i (term_w),
    .tick_o (tick_o),
    .sq_o   (sq_o)
  );

endmodule

// File: rtl/clkdiv_preload_chk.sv
module clkdiv_preload_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_o,
  input logic             sq_o,
  input logic             term,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH:0]   eff
);

  logic [WIDTH:0]   per_q;
  logic [WIDTH:0]   per_old;
  logic [WIDTH+1:0] gap;

  // Independent model of the period length and the cycles between pulses.
  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= eff;
      per_old <= eff;
      gap     <= '0;
    end else begin
      if (term) begin
        per_old <= per_q;
        per_q   <= eff;
      end
      gap <= tick_o ? {{(WIDTH+1){1'b0}}, 1'b1} : gap + 1'b1;
    end
  end

  // R1: pulses are spaced by the period that was loaded at the prior reload
  p_period_r1: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (gap == {1'b0, per_old}));

  // R2: back-to-back pulses only when the period is one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && $past(tick_o)) |-> (per_old == {{WIDTH{1'b0}}, 1'b1}));

  // R5: the square wave changes only together with a pulse
  p_sq_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (sq_o != $past(sq_o))) |-> tick_o);

  // R6: outputs quiet right after reset
  p_reset_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tick_o && !sq_o));

  // R7: the terminal cycle loads the start value sampled at that cycle
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt == $past(preset)));

endmodule

bind clkdiv_preload clkdiv_preload_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick_o (tick_o),
  .sq_o   (sq_o),
  .term   (term_w),
  .cnt    (cnt_w),
  .preset (preset_w),
  .eff    (eff_w)
);

// File: tb/sim_clkdiv_preload.sv
`timescale 1ns/1ps
module sim_clkdiv_preload;
  import clkdiv_pkg::*;

  localparam int W   = 4;
  localparam int DW  = W + 1;
  localparam int NV  = 9;
  localparam logic [DW-1:0] VDIV [NV] = '{5'd3, 5'd1, 5'd0, 5'd2, 5'd5, 5'd16, 5'd20, 5'd31, 5'd7};
  localparam int            VPER [NV] = '{3, 1, 1, 2, 5, 16, 16, 16, 7};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] div = 5'd3;
  logic          tick0, sq0, tick1, sq1;
  int            checks = 0;
  int            fails  = 0;

  always #2.5 clk = ~clk;

  clkdiv_preload #(.WIDTH(W), .MODE(CNT_DOWN)) u0 (
    .clk(clk), .rst(rst), .div_i(div), .tick_o(tick0), .sq_o(sq0));

  clkdiv_preload #(.WIDTH(W), .MODE(CNT_UP)) u1 (
    .clk(clk), .rst(rst), .div_i(div), .tick_o(tick1), .sq_o(sq1));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic et, input logic es);
    chk(req,  "u0 tick_o", tick0, et);
    chk("R5", "u0 sq_o",   sq0,   es);
    chk("R3", "u1 tick_o", tick1, et);
    chk("R3", "u1 sq_o",   sq1,   es);
  endtask

  // Ends at a falling edge; the next rising edge is edge 1 of R1.
  task automatic do_reset(input logic [DW-1:0] v);
    @(negedge clk);
    rst = 1'b1;
    div = v;
    @(negedge clk);
    chk_all("R6", 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic run_periods(input int n, input int nper, input string req);
    for (int k = 1; k <= n * nper; k++) begin
      @(negedge clk);
      chk_all((n > 1 && (k % n) == 1) ? "R2" : req,
              (k % n) == 0, ((k / n) % 2) == 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // Vector table: divisor in, period expected (R1, R4 saturation and zero)
    for (int i = 0; i < NV; i++) begin
      do_reset(VDIV[i]);
      run_periods(VPER[i], 3, (VDIV[i] != DW'(VPER[i])) ? "R4" : "R1");
    end

    // R6: reset in mid-run clears outputs and restarts the period
    do_reset(5'd3);
    run_periods(3, 1, "R6");
    @(negedge clk);
    chk_all("R6", 1'b0, 1'b1);
    do_reset(5'd3);
    run_periods(3, 2, "R6");

    // R7: divisor change inside a period; old period completes first
    do_reset(5'd5);
    for (int k = 1; k <= 2; k++) begin
      @(negedge clk);
      chk_all("R7", 1'b0, 1'b0);
    end
    div = 5'd3;
    for (int k = 3; k <= 14; k++) begin
      @(negedge clk);
      if (k < 5) chk_all("R7", 1'b0, 1'b0);
      else       chk_all("R7", ((k - 5) % 3) == 0, (((k - 5) / 3) % 2) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule